// File: doc/BRIEF.md
# Interrupt Request Aggregator and Forwarder

This block gathers one level-sensitive interrupt request line from each of sixteen peripheral sources into a 16-bit request register. It forwards that register to a host processor in two ways. First, a copy of the register goes out on a parallel 16-bit bus at a fixed, programmable interval, marked by a one-cycle strobe. Second, a single combined interrupt line is driven high whenever any in-use request is active.

The block neither ranks nor encodes the requests, because the host's own interrupt controller does that work. It has no enable or clear bits of its own. Each source module arms and clears its own request, so a request bit follows its input line and nothing else. Position 0 belongs to the system register unit, which leaves positions 1 to 15 for the other modules. A mask input tells the combined line which positions are not in use. The request register can be read directly at all times.

Top module: `irq_gather`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `req_reg`, `xfer_bus`, `xfer_stb` and `host_irq` are all 0.
- R2: Each bit of `req_reg` equals the matching `req_in` bit as sampled three rising edges earlier (two synchroniser stages plus the register stage). A bit falls as soon as its input has been low for that long; nothing is latched.
- R3: `req_in[i]` appears at bit i of both `req_reg` and `xfer_bus`, with no reordering or ranking. Bit 0 is the system register unit's request.
- R4: `xfer_stb` pulses high for one cycle after every P-th rising edge counted from reset release. The first pulse follows edge P.
- R5: In a strobe cycle, `xfer_bus` holds the value `req_reg` had just before that edge. Between strobes, `xfer_bus` does not change, whatever the requests do.
- R6: The period P equals `period_cfg` when it is nonzero. A `period_cfg` of 0 selects P = 64.
- R7: `host_irq` is 1 exactly when some bit is set in both `req_reg` and the inverse of `unused_mask`, where a mask bit of 1 marks an unused position. It follows `req_reg` and the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Asynchronous level interrupt requests, bit 0 from the system register unit |
| unused_mask | input | 16 | 1 marks a request position as unused for the combined line |
| period_cfg | input | 16 | Transfer period in clocks; 0 selects 64 |
| req_reg | output | 16 | Readable request register |
| xfer_bus | output | 16 | Parallel snapshot bus to the host |
| xfer_stb | output | 1 | One-cycle strobe marking a new snapshot |
| host_irq | output | 1 | Combined interrupt line |

## Verification
A change on `req_in` reaches `req_reg` after the third rising edge, so the bench checks the old value after edges one and two and the new value after edge three. `host_irq` is checked in the same cycle as `req_reg`. After reset release, the strobe and the new bus value are due just after edge P. The bench holds the requests steady through reset and counts exactly P edges. It confirms the strobe is low after edge P-1, high after edge P and low again after edge P+1. For the default period and for a request change made in the middle of a period, it samples at the edge before the transfer and at the transfer edge itself. All samples are taken on falling edges.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int NUM_SRC = 16;

    typedef logic [NUM_SRC-1:0] irq_vec_t;

    typedef struct packed {
        logic     stb;
        irq_vec_t data;
    } xfer_t;

    function automatic logic any_active(input irq_vec_t vec, input irq_vec_t unused);
        return |(vec & ~unused);
    endfunction

endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irqg_timer.sv
module irqg_timer #(
    parameter int PW         = 16,
    parameter int DEF_PERIOD = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] period_cfg,
    output logic          tick
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] limit;

    // A zero setting selects the built-in default period (R6)
    always_comb begin
        limit = (period_cfg == '0) ? PW'(DEF_PERIOD) : period_cfg;
        tick  = (cnt >= limit - PW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/irqg_snap.sv
module irqg_snap (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  irqg_pkg::irq_vec_t cur,
    output irqg_pkg::xfer_t    xfer
);
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer <= '0;
        end else begin
            xfer.stb <= tick;
            if (tick) xfer.data <= cur;
        end
    end
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter int PERIOD_W   = 16,
    parameter int DEF_PERIOD = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         req_in,
    input  logic [15:0]         unused_mask,
    input  logic [PERIOD_W-1:0] period_cfg,
    output logic [15:0]         req_reg,
    output logic [15:0]         xfer_bus,
    output logic                xfer_stb,
    output logic                host_irq
);
    import irqg_pkg::*;

    irq_vec_t synced;
    irq_vec_t reg_q;
    logic     tick;
    xfer_t    xfer;

    irqg_sync #(.W(NUM_SRC), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_in),
        .q   (synced)
    );

    // Request register, refreshed every clock from the synchronised levels
    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= synced;
    end

    irqg_timer #(.PW(PERIOD_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_cfg (period_cfg),
        .tick       (tick)
    );

    irqg_snap u_snap (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cur  (reg_q),
        .xfer (xfer)
    );

    assign req_reg  = reg_q;
    assign xfer_bus = xfer.data;
    assign xfer_stb = xfer.stb;
    assign host_irq = any_active(reg_q, unused_mask);
endmodule

// File: rtl/irqg_chk.sv
module irqg_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] req_in,
    input logic [15:0] unused_mask,
    input logic [15:0] req_reg,
    input logic [15:0] xfer_bus,
    input logic        xfer_stb,
    input logic        host_irq
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)             cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_reg == 16'h0 && xfer_bus == 16'h0 && !xfer_stb && !host_irq)); // R1

    AST_CAPTURE_DELAY: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |-> (req_reg == $past(req_in, 3))); // R2

    AST_SNAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        xfer_stb |-> (xfer_bus == $past(req_reg))); // R5

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!xfer_stb && cyc >= 2'd2) |-> $stable(xfer_bus)); // R5

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> ((req_reg & ~unused_mask) != 16'h0)); // R7

    AST_IRQ_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ((req_reg & ~unused_mask) == 16'h0) |-> !host_irq); // R7
endmodule

bind irq_gather irqg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_in      (req_in),
    .unused_mask (unused_mask),
    .req_reg     (req_reg),
    .xfer_bus    (xfer_bus),
    .xfer_stb    (xfer_stb),
    .host_irq    (host_irq)
);

// File: tb/test_irq_gather.sv
`timescale 1ns/1ps
module test_irq_gather;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_in = 16'h0;
    logic [15:0] unused_mask = 16'h0;
    logic [15:0] period_cfg = 16'd8;
    logic [15:0] req_reg;
    logic [15:0] xfer_bus;
    logic        xfer_stb;
    logic        host_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    irq_gather i_irq_gather (
        .clk         (clk),
        .rst         (rst),
        .req_in      (req_in),
        .unused_mask (unused_mask),
        .period_cfg  (period_cfg),
        .req_reg     (req_reg),
        .xfer_bus    (xfer_bus),
        .xfer_stb    (xfer_stb),
        .host_irq    (host_irq)
    );

    typedef struct packed {
        logic [15:0] req;
        logic [15:0] mask;
        logic [15:0] per;
        logic        irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{req: 16'h0001, mask: 16'h0000, per: 16'd4,  irq: 1'b1},
        '{req: 16'h8000, mask: 16'h8000, per: 16'd5,  irq: 1'b0},
        '{req: 16'hA5A5, mask: 16'h0000, per: 16'd6,  irq: 1'b1},
        '{req: 16'h00F0, mask: 16'hFF0F, per: 16'd7,  irq: 1'b1},
        '{req: 16'h0000, mask: 16'h0000, per: 16'd9,  irq: 1'b0},
        '{req: 16'hFFFF, mask: 16'hFFFE, per: 16'd4,  irq: 1'b1},
        '{req: 16'h0F00, mask: 16'h0F00, per: 16'd10, irq: 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        step(1);

        // R1: reset state with every request high
        req_in = 16'hFFFF;
        rst = 1'b1;
        step(3);
        check("R1 req_reg in reset", req_reg, 16'h0);
        check("R1 xfer_bus in reset", xfer_bus, 16'h0);
        check("R1 xfer_stb in reset", {15'h0, xfer_stb}, 16'h0);
        check("R1 host_irq in reset", {15'h0, host_irq}, 16'h0);
        rst = 1'b0;
        step(1);
        check("R1 req_reg after release", req_reg, 16'h0);
        check("R1 xfer_stb after release", {15'h0, xfer_stb}, 16'h0);

        // Table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            req_in      = VECS[v].req;
            unused_mask = VECS[v].mask;
            period_cfg  = VECS[v].per;
            do_reset();
            step(int'(VECS[v].per) - 1);
            check("R4 no strobe before period", {15'h0, xfer_stb}, 16'h0);
            step(1);
            check("R4 strobe at period", {15'h0, xfer_stb}, 16'h1);
            check("R3 bus positions", xfer_bus, VECS[v].req);
            check("R3 register positions", req_reg, VECS[v].req);
            check("R7 combined line", {15'h0, host_irq}, {15'h0, VECS[v].irq});
            step(1);
            check("R4 strobe single cycle", {15'h0, xfer_stb}, 16'h0);
            check("R5 bus held", xfer_bus, VECS[v].req);
        end

        // R2: three-edge capture latency, rise and fall
        unused_mask = 16'h0;
        period_cfg  = 16'd8;
        req_in      = 16'h0000;
        do_reset();
        step(5);
        req_in = 16'h0402;
        step(2);
        check("R2 old value after two edges", req_reg, 16'h0000);
        check("R7 line low before capture", {15'h0, host_irq}, 16'h0);
        step(1);
        check("R2 new value after three edges", req_reg, 16'h0402);
        check("R7 line high with capture", {15'h0, host_irq}, 16'h1);
        req_in = 16'h0400;
        step(2);
        check("R2 bit still set after two edges", req_reg, 16'h0402);
        step(1);
        check("R2 level drop after three edges", req_reg, 16'h0400);

        // R7: mask change acts in the same cycle
        unused_mask = 16'h0400;
        #0.1;
        check("R7 masked position ignored", {15'h0, host_irq}, 16'h0);
        check("R7 register keeps masked bit", req_reg, 16'h0400);
        unused_mask = 16'h0;

        // R5: request change mid-period waits for next transfer
        req_in     = 16'h1234;
        period_cfg = 16'd8;
        do_reset();
        step(8);
        check("R5 first snapshot", xfer_bus, 16'h1234);
        req_in = 16'h4321;
        step(4);
        check("R2 register updated mid-period", req_reg, 16'h4321);
        check("R5 bus unchanged mid-period", xfer_bus, 16'h1234);
        step(3);
        check("R5 bus unchanged before transfer", xfer_bus, 16'h1234);
        check("R4 no strobe before second transfer", {15'h0, xfer_stb}, 16'h0);
        step(1);
        check("R4 second strobe", {15'h0, xfer_stb}, 16'h1);
        check("R5 second snapshot", xfer_bus, 16'h4321);

        // R6: zero period selects 64
        req_in     = 16'h0001;
        period_cfg = 16'd0;
        do_reset();
        step(63);
        check("R6 no strobe at edge 63", {15'h0, xfer_stb}, 16'h0);
        step(1);
        check("R6 strobe at edge 64", {15'h0, xfer_stb}, 16'h1);
        check("R3 system unit bit forwarded", xfer_bus, 16'h0001);

        done = 1;
        report();
    end
endmodule